// File: doc/BRIEF.md
# Sampling-Tap Tuning Window Selector

This block runs the tuning sweep for a sampling-clock delay line. After a start request it walks the tap under test through every position twice. Each probe reports two flags: whether the probe transfer succeeded, and whether the sample-compare check reported no mismatch. At the end of the sweep the block treats a tap as good only when both of its probes agree. It then finds the longest stretch of good positions and selects the tap at its centre.

When every probe succeeded, the transfer results cannot tell the taps apart. In that case the block selects from the sample-compare results instead, and accepts a shorter window. If no window is long enough, it raises an error instead of a tap. A successful selection also turns on automatic re-tuning. The surrounding controller issues the probe commands. It watches `probe_tap` and `busy`, and reports each probe outcome with a one-cycle `probe_done` strobe.

Top module: `tap_window_tuner`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `retune_en` are low, and `probe_tap` and `sel_tap` are zero.
- R2: A `start` with tap count N in 1..MAX_TAPS begins a sweep of 2N probes. Probe i uses tap i mod N. `probe_tap` advances only on an accepted `probe_done`, and `busy` stays high until `done` rises.
- R3: For each result kind, a tap counts as good only if the probes of both passes at that tap reported success.
- R4: If all 2N probes succeeded, selection uses the sample-compare results with a minimum window of 1. Otherwise it uses the probe-success results with a minimum window of 3.
- R5: Windows are runs of consecutive good positions over positions 0..2N-1, where position p stands for tap p mod N. The longest run wins, and of equal-length runs the earliest is kept.
- R6: The selected tap is ((run_start + run_end_exclusive) / 2) mod N.
- R7: If the best run is shorter than the minimum, the block ends with `err` high, `sel_tap` zero and `retune_en` low.
- R8: A successful selection ends with `err` low, `retune_en` high and `sel_tap` holding the chosen tap.
- R9: `done` goes high on the clock edge after the edge that accepts the last probe. `done`, `err`, `sel_tap` and `retune_en` then hold until the next `start`.
- R10: A `start` with N = 0 finishes at the next edge with `done` high and `err` and `retune_en` low, and runs no sweep.
- R11: A `start` with N above MAX_TAPS finishes at the next edge with `done` and `err` high and runs no sweep.
- R12: A `start` takes priority over everything else. It clears the results of any earlier or unfinished sweep and restarts at tap 0.
- R13: `probe_done` while `busy` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tuning sweep |
| tap_count | input | CNT_W | Number of taps N, sampled at start and held during the sweep |
| probe_done | input | 1 | One-cycle strobe: the probe on `probe_tap` has finished |
| probe_pass | input | 1 | The probe transfer succeeded |
| cmp_pass | input | 1 | The sample-compare check reported no mismatch |
| probe_tap | output | TAP_W | Tap currently under test |
| busy | output | 1 | Sweep or evaluation in progress |
| sel_tap | output | TAP_W | Selected tap |
| done | output | 1 | Sweep finished, results valid |
| err | output | 1 | No usable window, or an unsupported tap count |
| retune_en | output | 1 | Automatic re-tuning enabled after a good selection |

## Verification
The bench aims at four corner cases:
- **Failure in one pass only.** A tap that fails only in the second pass must break the window. A design that did not merge the two passes would return a centre shifted into the bad tap.
- **Window wrapping past the last tap.** Such a window must count across the repeated tap order. A design that scanned only N positions would see a run too short and raise a false error.
- **Every probe passing.** The block must switch to the compare results with a minimum of 1. Sweeps with equal-length runs show whether a later tie wrongly replaces the earliest one.
- **Control edge cases.** These cover N of 0, 1 and above the maximum, a restart in the middle of a sweep, and stray strobes while idle. A design that got them wrong would hang busy, or corrupt a finished result.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_EVAL  = 2'd2
    } tune_state_e;
endpackage

// File: rtl/tap_result_store.sv
module tap_result_store #(
    parameter int MAX_TAPS = 8,
    parameter int TAP_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr_en,
    input  logic                wr_second,
    input  logic [TAP_W-1:0]    wr_tap,
    input  logic                pass_in,
    input  logic                cmp_in,
    output logic [MAX_TAPS-1:0] pass_a,
    output logic [MAX_TAPS-1:0] pass_b,
    output logic [MAX_TAPS-1:0] cmp_a,
    output logic [MAX_TAPS-1:0] cmp_b
);
    typedef struct packed {
        logic [MAX_TAPS-1:0] pa;
        logic [MAX_TAPS-1:0] pb;
        logic [MAX_TAPS-1:0] ca;
        logic [MAX_TAPS-1:0] cb;
    } maps_t;

    maps_t maps_q, maps_d;

    always_comb begin
        maps_d = maps_q;
        if (clear) begin
            maps_d = '0;
        end else if (wr_en) begin
            if (!wr_second) begin
                maps_d.pa[wr_tap] = pass_in;
                maps_d.ca[wr_tap] = cmp_in;
            end else begin
                maps_d.pb[wr_tap] = pass_in;
                maps_d.cb[wr_tap] = cmp_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) maps_q <= '0;
        else        maps_q <= maps_d;
    end

    assign pass_a = maps_q.pa;
    assign pass_b = maps_q.pb;
    assign cmp_a  = maps_q.ca;
    assign cmp_b  = maps_q.cb;
endmodule

// File: rtl/tap_window_eval.sv
module tap_window_eval #(
    parameter int MAX_TAPS       = 8,
    parameter int TAP_W          = 3,
    parameter int CNT_W          = 4,
    parameter int MIN_RUN_STRICT = 3,
    parameter int MIN_RUN_FULL   = 1
) (
    input  logic [CNT_W-1:0]    n_taps,
    input  logic [MAX_TAPS-1:0] pass_a,
    input  logic [MAX_TAPS-1:0] pass_b,
    input  logic [MAX_TAPS-1:0] cmp_a,
    input  logic [MAX_TAPS-1:0] cmp_b,
    output logic [TAP_W-1:0]    tap_out,
    output logic                found
);
    localparam int POS_N = 2 * MAX_TAPS;
    localparam int POS_W = $clog2(POS_N + 1);

    logic [MAX_TAPS-1:0] lane_on;
    logic [MAX_TAPS-1:0] good_pass, good_cmp, src;
    logic                all_pass;
    logic [POS_N-1:0]    src_ext, doubled;
    logic [POS_W-1:0]    run_len, run_s, best_len, best_s, best_e, min_len;
    logic [POS_W:0]      pos_sum;
    logic [POS_W-1:0]    mid, n_ext;

    for (genvar k = 0; k < MAX_TAPS; k++) begin : g_lane
        assign lane_on[k] = (n_taps > CNT_W'(k));
    end

    // R3: a tap is good only if both passes agree
    assign good_pass = pass_a & pass_b & lane_on;
    assign good_cmp  = cmp_a & cmp_b & lane_on;
    // R4: choose the result kind and the minimum window
    assign all_pass  = &(good_pass | ~lane_on);
    assign src       = all_pass ? good_cmp : good_pass;
    assign min_len   = all_pass ? POS_W'(MIN_RUN_FULL) : POS_W'(MIN_RUN_STRICT);

    assign src_ext = POS_N'(src);
    assign doubled = src_ext | (src_ext << n_taps);
    assign n_ext   = POS_W'(n_taps);

    // R5: longest run, ties keep the earliest
    always_comb begin
        run_len  = '0;
        run_s    = '0;
        best_len = '0;
        best_s   = '0;
        best_e   = '0;
        for (int j = 0; j < POS_N; j++) begin
            if (doubled[j]) begin
                if (run_len == '0) run_s = POS_W'(j);
                run_len = run_len + POS_W'(1);
                if (run_len > best_len) begin
                    best_len = run_len;
                    best_s   = run_s;
                    best_e   = POS_W'(j + 1);
                end
            end else begin
                run_len = '0;
            end
        end
    end

    // R6: centre of the window, folded back into 0..N-1
    assign pos_sum = {1'b0, best_s} + {1'b0, best_e};
    assign mid     = pos_sum[POS_W:1];
    assign tap_out = (mid >= n_ext) ? TAP_W'(mid - n_ext) : TAP_W'(mid);
    assign found   = (best_len >= min_len);
endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner
    import tap_tune_pkg::*;
#(
    parameter int MAX_TAPS       = 8,
    parameter int MIN_RUN_STRICT = 3,
    parameter int MIN_RUN_FULL   = 1,
    localparam int TAP_W = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1,
    localparam int CNT_W = $clog2(MAX_TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] tap_count,
    input  logic             probe_done,
    input  logic             probe_pass,
    input  logic             cmp_pass,
    output logic [TAP_W-1:0] probe_tap,
    output logic             busy,
    output logic [TAP_W-1:0] sel_tap,
    output logic             done,
    output logic             err,
    output logic             retune_en
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_TAPS);

    typedef struct packed {
        tune_state_e      st;
        logic [TAP_W-1:0] tap;
        logic             second;
        logic [TAP_W-1:0] sel;
        logic             done;
        logic             err;
        logic             retune;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [MAX_TAPS-1:0] pass_a, pass_b, cmp_a, cmp_b;
    logic [TAP_W-1:0]    eval_tap;
    logic                eval_found;
    logic                wr_en;
    logic [CNT_W-1:0]    last_tap;

    assign last_tap = tap_count - CNT_W'(1);
    assign wr_en    = !start && (ctl_q.st == ST_PROBE) && probe_done;

    tap_result_store #(.MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .wr_en     (wr_en),
        .wr_second (ctl_q.second),
        .wr_tap    (ctl_q.tap),
        .pass_in   (probe_pass),
        .cmp_in    (cmp_pass),
        .pass_a    (pass_a),
        .pass_b    (pass_b),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b)
    );

    tap_window_eval #(
        .MAX_TAPS      (MAX_TAPS),
        .TAP_W         (TAP_W),
        .CNT_W         (CNT_W),
        .MIN_RUN_STRICT(MIN_RUN_STRICT),
        .MIN_RUN_FULL  (MIN_RUN_FULL)
    ) u_eval (
        .n_taps  (tap_count),
        .pass_a  (pass_a),
        .pass_b  (pass_b),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .tap_out (eval_tap),
        .found   (eval_found)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.tap    = '0;
            ctl_d.second = 1'b0;
            ctl_d.sel    = '0;
            ctl_d.done   = 1'b0;
            ctl_d.err    = 1'b0;
            ctl_d.retune = 1'b0;
            if (tap_count == '0) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end else if (tap_count > MAX_CNT) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
                ctl_d.err  = 1'b1;
            end else begin
                ctl_d.st = ST_PROBE;
            end
        end else begin
            unique case (ctl_q.st)
                ST_PROBE: begin
                    if (probe_done) begin
                        if (CNT_W'(ctl_q.tap) == last_tap) begin
                            ctl_d.tap = '0;
                            if (ctl_q.second) ctl_d.st = ST_EVAL;
                            else              ctl_d.second = 1'b1;
                        end else begin
                            ctl_d.tap = ctl_q.tap + TAP_W'(1);
                        end
                    end
                end
                ST_EVAL: begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.done   = 1'b1;
                    ctl_d.err    = !eval_found;
                    ctl_d.retune = eval_found;
                    ctl_d.sel    = eval_found ? eval_tap : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.tap    <= '0;
            ctl_q.second <= 1'b0;
            ctl_q.sel    <= '0;
            ctl_q.done   <= 1'b0;
            ctl_q.err    <= 1'b0;
            ctl_q.retune <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign probe_tap = ctl_q.tap;
    assign busy      = (ctl_q.st != ST_IDLE);
    assign sel_tap   = ctl_q.sel;
    assign done      = ctl_q.done;
    assign err       = ctl_q.err;
    assign retune_en = ctl_q.retune;
endmodule

// File: rtl/tap_window_tuner_chk.sv
module tap_window_tuner_chk #(
    parameter int MAX_TAPS = 8,
    parameter int TAP_W    = 3,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] tap_count,
    input logic             probe_done,
    input logic [TAP_W-1:0] probe_tap,
    input logic             busy,
    input logic [TAP_W-1:0] sel_tap,
    input logic             done,
    input logic             err,
    input logic             retune_en
);
    assert_busy_not_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_tap_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !probe_done && !start) |=> $stable(probe_tap));

    assert_err_zero_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (sel_tap == '0 && !retune_en));

    assert_retune_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retune_en |-> (done && !err));

    assert_start_restarts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tap_count != '0 && tap_count <= CNT_W'(MAX_TAPS))
        |=> (busy && !done && probe_tap == '0));

    assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(err) && $stable(sel_tap)
                               && $stable(retune_en) && !busy));
endmodule

bind tap_window_tuner tap_window_tuner_chk #(
    .MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
    .probe_done(probe_done), .probe_tap(probe_tap), .busy(busy),
    .sel_tap(sel_tap), .done(done), .err(err), .retune_en(retune_en)
);

// File: tb/tb_tap_window_tuner.sv
`timescale 1ns/1ps
module tb_tap_window_tuner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] tap_count = '0;
    logic       probe_done = 1'b0, probe_pass = 1'b0, cmp_pass = 1'b0;
    logic [2:0] probe_tap, sel_tap;
    logic       busy, done, err, retune_en;

    int checks = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tap_window_tuner dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
        .probe_done(probe_done), .probe_pass(probe_pass), .cmp_pass(cmp_pass),
        .probe_tap(probe_tap), .busy(busy), .sel_tap(sel_tap), .done(done),
        .err(err), .retune_en(retune_en)
    );

    // behavioural reference model
    int        m_n = 0, m_k = 0, m_tap = 0, m_sel = 0;
    bit        m_busy = 0, m_eval = 0, m_done = 0, m_err = 0, m_ret = 0;
    bit [15:0] m_ok, m_cm;

    function automatic void pick(input int n, input bit [15:0] okm, input bit [15:0] cmm,
                                 output int tap, output bit good);
        bit [15:0] a = okm, c = cmm, use_map;
        bit full = 1;
        int minrow, rs, re, s = 0, e = 0, cnt = 0, i;
        for (int q = 0; q < 2 * n; q++) begin
            int off = (q < n) ? n : -n;
            if (!a[q]) a[q + off] = 0;
            if (!c[q]) c[q + off] = 0;
        end
        for (int q = 0; q < 2 * n; q++) if (!a[q]) full = 0;
        use_map = full ? c : a;
        minrow  = full ? 1 : 3;
        i = 0;
        while (i < 2 * n) begin
            if (use_map[i]) begin
                rs = i;
                while (i < 2 * n && use_map[i]) i++;
                re = i;
                if (re - rs > cnt) begin s = rs; e = re; cnt = re - rs; end
            end else i++;
        end
        good = (cnt >= minrow);
        tap  = good ? ((s + e) / 2) % n : 0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_eval = 0; m_done = 0; m_err = 0; m_ret = 0;
            m_tap = 0; m_sel = 0; m_k = 0;
        end else if (start) begin
            m_n = int'(tap_count); m_k = 0; m_tap = 0; m_ok = '0; m_cm = '0;
            m_sel = 0; m_ret = 0; m_eval = 0;
            if (m_n == 0)      begin m_busy = 0; m_done = 1; m_err = 0; end
            else if (m_n > 8)  begin m_busy = 0; m_done = 1; m_err = 1; end
            else               begin m_busy = 1; m_done = 0; m_err = 0; end
        end else if (m_eval) begin
            int t; bit g;
            pick(m_n, m_ok, m_cm, t, g);
            m_eval = 0; m_busy = 0; m_done = 1;
            m_err = !g; m_ret = g; m_sel = t;
        end else if (m_busy && probe_done) begin
            m_ok[m_k] = probe_pass;
            m_cm[m_k] = cmp_pass;
            m_k++;
            m_tap = m_k % m_n;
            if (m_k == 2 * m_n) m_eval = 1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 probe_tap", int'(probe_tap), m_tap);
            chk("R2 busy", int'(busy), int'(m_busy));
            chk("R9 done", int'(done), int'(m_done));
            chk("R7 err", int'(err), int'(m_err));
            chk("R6 sel_tap", int'(sel_tap), m_sel);
            chk("R8 retune_en", int'(retune_en), int'(m_ret));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic kick(input int n);
        tap_count = 4'(n); start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic probe(input bit p, input bit c);
        probe_done = 1'b1; probe_pass = p; cmp_pass = c; tick();
        probe_done = 1'b0; probe_pass = 1'b0; cmp_pass = 1'b0; tick();
    endtask

    task automatic sweep(input int n, input bit [7:0] p1, input bit [7:0] p2,
                         input bit [7:0] c1, input bit [7:0] c2);
        kick(n);
        for (int i = 0; i < 2 * n; i++) begin
            int t = i % n;
            if (i < n) probe(p1[t], c1[t]);
            else       probe(p2[t], c2[t]);
        end
        tick();
    endtask

    task automatic expect_end(input string tag, input int e_err, input int e_sel, input int e_ret);
        @(negedge clk);
        chk({tag, " done"}, int'(done), 1);
        chk({tag, " err"}, int'(err), e_err);
        chk({tag, " sel_tap"}, int'(sel_tap), e_sel);
        chk({tag, " retune_en"}, int'(retune_en), e_ret);
        tick();
    endtask

    initial begin : watchdog
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        // R1: reset state
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 retune_en", int'(retune_en), 0);
        chk("R1 probe_tap", int'(probe_tap), 0);
        chk("R1 sel_tap", int'(sel_tap), 0);
        rst_n = 1'b1;
        tick();

        // R4 R5: all probes pass, compare fails at taps 6,7; tie keeps earliest -> 3
        sweep(8, 8'hFF, 8'hFF, 8'h3F, 8'h3F);
        expect_end("R4 R5", 0, 3, 1);

        // R3 R6: tap 2 fails only in pass two -> window 3..10 -> tap 6
        sweep(8, 8'hFF, 8'hFB, 8'h00, 8'h00);
        expect_end("R3 R6", 0, 6, 1);

        // R7: only tap 1 good, run of 1 < 3
        sweep(4, 8'h02, 8'h02, 8'h0F, 8'h0F);
        expect_end("R7", 1, 0, 0);

        // R5 R6: wrap window, N=6 good at 4,5,0 -> positions 4..6 -> tap 5
        sweep(6, 8'h31, 8'h31, 8'h00, 8'h00);
        expect_end("R5 wrap", 0, 5, 1);

        // R4 R8: N=5 everything passes -> whole 0..10 -> tap 0
        sweep(5, 8'h1F, 8'h1F, 8'h1F, 8'h1F);
        expect_end("R4 R8", 0, 0, 1);

        // R4: N=1 single tap all good
        sweep(1, 8'h01, 8'h01, 8'h01, 8'h01);
        expect_end("R4 n1", 0, 0, 1);

        // R10: N=0
        kick(0);
        expect_end("R10", 0, 0, 0);

        // R11: N above maximum
        kick(9);
        expect_end("R11", 1, 0, 0);

        // R12: restart mid-sweep after failing probes
        kick(4);
        probe(1'b0, 1'b0);
        probe(1'b0, 1'b0);
        @(negedge clk);
        chk("R12 mid busy", int'(busy), 1);
        chk("R12 mid tap", int'(probe_tap), 2);
        sweep(4, 8'h0E, 8'h0E, 8'h00, 8'h00);
        expect_end("R12", 0, 2, 1);

        // R13: strobes while idle change nothing
        probe(1'b0, 1'b0);
        probe(1'b1, 1'b1);
        @(negedge clk);
        chk("R13 done", int'(done), 1);
        chk("R13 sel_tap", int'(sel_tap), 2);
        chk("R13 retune_en", int'(retune_en), 1);
        chk("R13 probe_tap", int'(probe_tap), 0);
        tick();

        // R9: done exactly one edge after last accepted probe
        kick(2);
        for (int i = 0; i < 3; i++) probe(1'b1, 1'b1);
        probe_done = 1'b1; probe_pass = 1'b1; cmp_pass = 1'b1; tick();
        probe_done = 1'b0;
        @(negedge clk);
        chk("R9 not yet", int'(done), 0);
        tick();
        @(negedge clk);
        chk("R9 done", int'(done), 1);
        chk("R9 sel_tap", int'(sel_tap), 0);
        tick(); tick();

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule